// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the slave side of a 128-byte serial memory on a two-wire bus. It samples the bus clock and data lines on the system clock and detects Start and Stop conditions. It answers a control byte whose top four bits carry a fixed device code. After that it takes a word address and then data bytes, or it streams stored bytes back to the master. The array is ordinary flip-flops. Write data goes first into an eight-byte page buffer. That buffer is copied into the array by a self-timed commit, which starts when the master sends Stop. While the commit runs, the block takes no part in bus traffic.

A write-enable input arms programming. It is sampled when a write control byte is accepted. Later changes to that input, including during the commit, have no effect on a write that has already been set up. On the data line the block only pulls low or releases. The `sda_pull_low` output tells the pad when to pull the line low.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset, `sda_pull_low` and `busy` are both low.
- R2: A control byte is acknowledged only when its bits 7:4 equal 1010 and no commit is running. Bits 3:1 are ignored. Bit 0 selects read (1) or write (0).
- R3: An accepted byte is acknowledged by pulling the data line low for the whole ninth clock. The line is released after that clock's falling edge. The block changes its data-line drive only while the clock is low.
- R4: In a write, the byte after the control byte loads the 7-bit address pointer. A single data byte followed by Stop is stored at that address.
- R5: Up to eight data bytes are held in a page buffer. They reach the array only after Stop. A repeated Start without Stop discards them.
- R6: After each written byte, only pointer bits 2:0 advance, and they wrap from 7 to 0. Bits 6:3 stay fixed. A ninth or later byte overwrites the buffer slot it lands on.
- R7: After a Stop that ends a write with buffered data, `busy` is high for exactly WRITE_CYCLES clocks, and the block rises `busy` only then. While `busy` is high, no control byte is acknowledged and the data line is never pulled low.
- R8: If `wr_en` is low when the write control byte is accepted, Stop leaves the array unchanged and `busy` stays low. Dropping `wr_en` after the setup does not cancel the write.
- R9: A read returns the byte at the pointer, most significant bit first. The full 7-bit pointer advances after each byte and wraps from 127 to 0. A master not-acknowledge releases the line.
- R10: A Start in any state drops partial framing. A new control byte sent after it is handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| wr_en | input | 1 | Programming enable, sampled at write setup |
| sda_pull_low | output | 1 | High to pull the data line low |
| busy | output | 1 | Self-timed commit in progress |

## Verification
The bench sends ten data bytes that start two slots below a page end, then reads the page and the byte after it. A design that carried the increment into bit 3, or that dropped the late bytes, would put data in the wrong page or leave old data. It sends a control byte in the middle of a commit and expects no acknowledge; a design that answered there would let a read race the commit. It drops `wr_en` both before setup and during a commit, to tell a gate sampled at setup from one sampled at Stop. It also runs a repeated Start after a partial byte and reads across address 127, which would expose stale bit counts and a pointer that wraps only inside a page.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    M_IDLE,
    M_CTRL,
    M_ADDR,
    M_WDATA,
    M_READ,
    M_WAIT
  } modeT;

  // strobes from the controller to the datapath, one cycle each
  typedef struct packed {
    logic shiftIn;
    logic setPtr;
    logic bufWr;
    logic bufClr;
    logic loadTx;
    logic shiftTx;
    logic commit;
  } strobeT;

endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sclHigh,
  output logic sdaBit,
  output logic sclRise,
  output logic sclFall,
  output logic startEvt,
  output logic stopEvt
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[MSB-1:0], scl_in};
      sdaPipe <= {sdaPipe[MSB-1:0], sda_in};
      sclPrev <= sclPipe[MSB];
      sdaPrev <= sdaPipe[MSB];
    end
  end

  assign sclHigh  = sclPipe[MSB];
  assign sdaBit   = sdaPipe[MSB];
  assign sclRise  = sclHigh & ~sclPrev;
  assign sclFall  = ~sclHigh & sclPrev;
  assign startEvt = sclHigh & sclPrev & sdaPrev & ~sdaBit;
  assign stopEvt  = sclHigh & sclPrev & ~sdaPrev & sdaBit;

endmodule

// File: rtl/eep_data.sv
module eep_data
  import eep_pkg::*;
#(
  parameter int         ADDR_W   = 7,
  parameter int         PAGE_W   = 3,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic   clk,
  input  logic   rst_n,
  input  strobeT strobe,
  input  logic   sdaBit,
  output logic   devMatch,
  output logic   rwBit,
  output logic   txMsb,
  output logic   anyValid
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;

  logic [7:0]        mem     [DEPTH];
  logic [7:0]        pageBuf [PAGE];
  logic [PAGE-1:0]   valid;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        rxShift, txShift, rxNext;

  assign rxNext   = {rxShift[6:0], sdaBit};
  assign devMatch = (rxNext[7:4] == DEV_CODE);
  assign rwBit    = rxNext[0];
  assign txMsb    = txShift[7];
  assign anyValid = |valid;

  // shift registers and pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxShift <= '0;
      txShift <= '0;
      ptr     <= '0;
    end else begin
      if (strobe.shiftIn) rxShift <= rxNext;
      if (strobe.setPtr) begin
        ptr <= rxNext[ADDR_W-1:0];
      end else if (strobe.bufWr) begin
        ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
      end else if (strobe.loadTx) begin
        ptr <= ptr + 1'b1;
      end
      if (strobe.loadTx) begin
        txShift <= mem[ptr];
      end else if (strobe.shiftTx) begin
        txShift <= {txShift[6:0], 1'b0};
      end
    end
  end

  // page buffer with per-slot valid flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= '0;
      for (int i = 0; i < PAGE; i++) pageBuf[i] <= '0;
    end else begin
      if (strobe.bufClr || strobe.commit) begin
        valid <= '0;
      end else if (strobe.bufWr) begin
        pageBuf[ptr[PAGE_W-1:0]] <= rxNext;
        valid[ptr[PAGE_W-1:0]]   <= 1'b1;
      end
    end
  end

  // storage array, written only by a commit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strobe.commit) begin
      for (int i = 0; i < PAGE; i++) begin
        if (valid[i]) mem[{ptr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pageBuf[i];
      end
    end
  end

endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int WRITE_CYCLES = 1000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sclRise,
  input  logic   sclFall,
  input  logic   startEvt,
  input  logic   stopEvt,
  input  logic   sdaBit,
  input  logic   wrEnable,
  input  logic   devMatch,
  input  logic   rwBit,
  input  logic   anyValid,
  output strobeT strobe,
  output logic   ackDrive,
  output logic   txOn,
  output logic   busy
);

  localparam int CW = $clog2(WRITE_CYCLES + 1);

  modeT          mode, nextMode;
  logic [3:0]    bitCnt;
  logic          inAck, ackPend, armed, masterAck;
  logic [CW-1:0] busyCnt;
  logic          rxMode, takeBit, byteDone, commitOk;

  assign rxMode   = (mode == M_CTRL) || (mode == M_ADDR) || (mode == M_WDATA);
  assign takeBit  = rxMode && sclRise && !inAck && (bitCnt < 4'd8);
  assign byteDone = takeBit && (bitCnt == 4'd7);
  assign busy     = (busyCnt != '0);
  assign commitOk = (mode == M_WDATA) && armed && anyValid && !busy;

  always_comb begin
    strobe         = '0;
    strobe.shiftIn = takeBit;
    strobe.bufClr  = byteDone && (mode == M_CTRL) && devMatch && !busy && !rwBit;
    strobe.setPtr  = byteDone && (mode == M_ADDR);
    strobe.bufWr   = byteDone && (mode == M_WDATA);
    strobe.loadTx  = sclFall && ((rxMode && inAck && (nextMode == M_READ)) ||
                                 ((mode == M_READ) && (bitCnt == 4'd9) && masterAck));
    strobe.shiftTx = sclFall && (mode == M_READ) && (bitCnt >= 4'd1) && (bitCnt <= 4'd7);
    strobe.commit  = (busyCnt == CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyCnt <= '0;
    end else if (stopEvt && commitOk) begin
      busyCnt <= CW'(WRITE_CYCLES);
    end else if (busy) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= M_IDLE;
      nextMode  <= M_IDLE;
      bitCnt    <= '0;
      inAck     <= 1'b0;
      ackPend   <= 1'b0;
      ackDrive  <= 1'b0;
      txOn      <= 1'b0;
      armed     <= 1'b0;
      masterAck <= 1'b0;
    end else if (startEvt || stopEvt) begin
      mode     <= startEvt ? M_CTRL : M_IDLE;
      bitCnt   <= '0;
      inAck    <= 1'b0;
      ackDrive <= 1'b0;
      txOn     <= 1'b0;
    end else if (rxMode) begin
      if (takeBit) begin
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == 4'd7) begin
          case (mode)
            M_CTRL: begin
              if (devMatch && !busy) begin
                ackPend  <= 1'b1;
                nextMode <= rwBit ? M_READ : M_ADDR;
                if (!rwBit) armed <= wrEnable;
              end else begin
                ackPend  <= 1'b0;
                nextMode <= M_WAIT;
              end
            end
            default: begin
              ackPend  <= 1'b1;
              nextMode <= M_WDATA;
            end
          endcase
        end
      end else if (sclFall && !inAck && (bitCnt == 4'd8)) begin
        inAck    <= 1'b1;
        ackDrive <= ackPend;
      end else if (sclFall && inAck) begin
        inAck    <= 1'b0;
        ackDrive <= 1'b0;
        bitCnt   <= '0;
        mode     <= nextMode;
        txOn     <= (nextMode == M_READ);
      end
    end else if (mode == M_READ) begin
      if (sclRise) begin
        if (bitCnt < 4'd8) begin
          bitCnt <= bitCnt + 1'b1;
        end else if (bitCnt == 4'd8) begin
          masterAck <= ~sdaBit;
          bitCnt    <= 4'd9;
        end
      end else if (sclFall) begin
        if (bitCnt == 4'd8) begin
          txOn <= 1'b0;
        end else if (bitCnt == 4'd9) begin
          if (masterAck) begin
            bitCnt <= '0;
            txOn   <= 1'b1;
          end else begin
            mode <= M_WAIT;
          end
        end
      end
    end
  end

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import eep_pkg::*;
#(
  parameter int WRITE_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic wr_en,
  output logic sda_pull_low,
  output logic busy
);

  logic   sclHigh, sdaBit, sclRise, sclFall, startEvt, stopEvt;
  logic   devMatch, rwBit, txMsb, anyValid, ackDrive, txOn;
  strobeT strobe;

  eep_bus_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sclHigh(sclHigh), .sdaBit(sdaBit), .sclRise(sclRise), .sclFall(sclFall),
    .startEvt(startEvt), .stopEvt(stopEvt)
  );

  eep_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sclRise(sclRise), .sclFall(sclFall),
    .startEvt(startEvt), .stopEvt(stopEvt), .sdaBit(sdaBit), .wrEnable(wr_en),
    .devMatch(devMatch), .rwBit(rwBit), .anyValid(anyValid),
    .strobe(strobe), .ackDrive(ackDrive), .txOn(txOn), .busy(busy)
  );

  eep_data #(.ADDR_W(7), .PAGE_W(3), .DEV_CODE(4'b1010)) u_data (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sdaBit(sdaBit),
    .devMatch(devMatch), .rwBit(rwBit), .txMsb(txMsb), .anyValid(anyValid)
  );

  assign sda_pull_low = ackDrive | (txOn & ~txMsb);

endmodule

// File: rtl/serial_eeprom_slave_chk.sv
module serial_eeprom_slave_chk #(
  parameter int WRITE_CYCLES = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic sda_pull_low,
  input logic sclHigh,
  input logic startEvt,
  input logic stopEvt
);

  logic [31:0] busyRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busyRun <= '0;
    else        busyRun <= busy ? busyRun + 1'b1 : '0;
  end

  assert_busy_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busyRun <= 32'(WRITE_CYCLES));

  assert_busy_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stopEvt));

  assert_silent_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull_low);

  assert_drive_while_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_low) |-> !$past(sclHigh));

  assert_start_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
    startEvt |=> !sda_pull_low);

endmodule

bind serial_eeprom_slave serial_eeprom_slave_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sda_pull_low(sda_pull_low),
  .sclHigh(sclHigh), .startEvt(startEvt), .stopEvt(stopEvt)
);

// File: tb/serial_eeprom_slave_tb.sv
module serial_eeprom_slave_tb;

  localparam int WC = 600;
  localparam int Q  = 8;
  localparam logic [23:0] VEC [6] = '{
    24'hA0_05_3C, 24'hA2_10_C5, 24'hAE_7F_81,
    24'hAA_3A_5E, 24'hA4_41_96, 24'hAC_00_E7
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, wrEn = 1'b1;
  logic dutLow, busy, line;
  logic [7:0] model [128];
  logic [7:0] rdBuf [16];
  int nChecks = 0, nFail = 0;

  always #4 clk = ~clk;

  assign line = sdaM & ~dutLow;

  serial_eeprom_slave #(.WRITE_CYCLES(WC)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(sclM), .sda_in(line),
    .wr_en(wrEn), .sda_pull_low(dutLow), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitClk(Q);
    sclM = 1'b1; waitClk(Q);
    sdaM = 1'b0; waitClk(Q);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitClk(Q);
    sclM = 1'b1; waitClk(Q);
    sdaM = 1'b1; waitClk(Q);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b;    waitClk(Q);
    sclM = 1'b1; waitClk(2*Q);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; waitClk(Q);
    sclM = 1'b1; waitClk(Q);
    acked = ~line;
    waitClk(Q);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitClk(Q);
      sclM = 1'b1; waitClk(Q);
      b[i] = line;
      waitClk(Q);
      sclM = 1'b0;
    end
    waitClk(Q);
    sdaM = ~ackIt; waitClk(Q);
    sclM = 1'b1;   waitClk(2*Q);
    sclM = 1'b0;   waitClk(Q);
    sdaM = 1'b1;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
  endtask

  task automatic writeBytes(input logic [7:0] ctrl, input logic [6:0] addr,
                            input int n, input logic [7:0] base, input string tag);
    logic a;
    busStart();
    sendByte(ctrl, a);               chk({tag, " ctrl ack"}, a, 1);
    sendByte({1'b0, addr}, a);       chk({tag, " addr ack"}, a, 1);
    for (int k = 0; k < n; k++) begin
      sendByte(base + 8'(k), a);
      if (wrEn) model[{addr[6:3], 3'(addr[2:0] + 3'(k))}] = base + 8'(k);
    end
    chk({tag, " last data ack R3"}, a, 1);
    chk({tag, " released after ack R3"}, dutLow, 0);
  endtask

  task automatic readAt(input logic [6:0] addr, input int n);
    logic a;
    logic [7:0] b;
    busStart();
    sendByte(8'hA0, a);
    sendByte({1'b0, addr}, a);
    busStart();
    sendByte(8'hA1, a);
    for (int k = 0; k < n; k++) begin
      readByte(k != n - 1, b);
      rdBuf[k] = b;
    end
    busStop();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin : main
    logic a;
    logic [7:0] b;
    int cnt;
    for (int i = 0; i < 128; i++) model[i] = 8'h00;

    waitClk(3);
    chk("R1 reset sda", dutLow, 0);
    chk("R1 reset busy", busy, 0);
    rst_n = 1'b1;
    waitClk(4);
    chk("R1 after reset sda", dutLow, 0);
    chk("R1 after reset busy", busy, 0);

    // R2 R4: byte writes with varied ignored bits, then read back
    for (int v = 0; v < 6; v++) begin
      writeBytes(VEC[v][23:16], VEC[v][14:8], 1, VEC[v][7:0], "R2 R4 table");
      busStop();
      chk("R7 busy after byte write", busy, 1);
      waitIdle();
      readAt(VEC[v][14:8], 1);
      chk("R4 table readback", rdBuf[0], model[VEC[v][14:8]]);
    end

    // R2: wrong device codes are not acknowledged
    busStart(); sendByte(8'hB0, a); chk("R2 code 1011 nack", a, 0); busStop();
    busStart(); sendByte(8'h21, a); chk("R2 code 0010 nack", a, 0); busStop();

    // R7: busy length measured from the Stop edge
    writeBytes(8'hA0, 7'h60, 1, 8'h77, "R7 len");
    sdaM = 1'b0; waitClk(Q);
    sclM = 1'b1; waitClk(Q);
    sdaM = 1'b1;
    cnt = 0;
    for (int i = 0; i < WC + 200; i++) begin
      @(negedge clk);
      if (busy) cnt++;
    end
    chk("R7 busy cycles", cnt, WC);

    // R7: control byte during commit is ignored
    writeBytes(8'hA0, 7'h61, 1, 8'h78, "R7 nack");
    busStop();
    busStart(); sendByte(8'hA1, a);
    chk("R7 busy still high", busy, 1);
    chk("R7 no ack while busy", a, 0);
    busStop();
    waitIdle();

    // R5: full page, committed after Stop
    writeBytes(8'hA0, 7'h20, 8, 8'h11, "R5 page");
    busStop(); waitIdle();
    readAt(7'h20, 8);
    for (int k = 0; k < 8; k++) chk("R5 page readback", rdBuf[k], model[7'h20 + k]);

    // R5: repeated Start without Stop discards buffered data
    writeBytes(8'hA0, 7'h20, 1, 8'hEE, "R5 abort");
    model[7'h20] = 8'h11;
    readAt(7'h20, 1);
    chk("R5 no commit without stop", rdBuf[0], 8'h11);
    chk("R5 no busy without stop", busy, 0);

    // R6: ten bytes two slots below page end wrap and overwrite
    writeBytes(8'hA0, 7'h4E, 10, 8'hD0, "R6 wrap");
    busStop(); waitIdle();
    readAt(7'h48, 9);
    for (int k = 0; k < 8; k++) chk("R6 wrapped page", rdBuf[k], 8'hD2 + 8'(k));
    chk("R6 next page untouched R9 crossing", rdBuf[8], 8'h00);

    // R9: sequential read across 127 to 0, then current-address read
    readAt(7'h7F, 2);
    chk("R9 byte at 127", rdBuf[0], 8'h81);
    chk("R9 wrap to 0", rdBuf[1], 8'hE7);
    readAt(7'h0F, 1);
    busStart(); sendByte(8'hA1, a);
    readByte(1'b0, b);
    chk("R9 released after nack", dutLow, 0);
    busStop();
    chk("R9 current address read", b, 8'hC5);

    // R8: enable low at setup blocks programming
    wrEn = 1'b0;
    writeBytes(8'hA0, 7'h30, 1, 8'h5A, "R8 off");
    busStop(); waitClk(20);
    chk("R8 no busy when disabled", busy, 0);
    readAt(7'h30, 1);
    chk("R8 array unchanged", rdBuf[0], 8'h00);
    wrEn = 1'b1;
    writeBytes(8'hA0, 7'h31, 1, 8'hC3, "R8 drop");
    busStop();
    wrEn = 1'b0;
    chk("R8 busy with late drop", busy, 1);
    waitIdle();
    readAt(7'h31, 1);
    chk("R8 write survives drop", rdBuf[0], 8'hC3);
    wrEn = 1'b1;

    // R10: Start after a partial byte restarts framing
    readAt(7'h7F, 1);
    busStart();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    busStart();
    sendByte(8'hA1, a);
    chk("R10 ack after restart", a, 1);
    readByte(1'b0, b);
    busStop();
    chk("R10 read after restart", b, 8'hE7);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule